// File: doc/BRIEF.md
# Immediate-Controlled Packed Lane Blend Unit

This execution block merges 256-bit vector operands one 32-bit lane at a time. An 8-bit immediate mask gives each lane its own select bit. When the bit is set, the lane is copied from the second source. When it is clear, the lane comes from the first source. Lane contents are copied bit for bit and are never interpreted as numbers, so NaN and denormal patterns pass through untouched and no arithmetic flag is ever raised.

A 2-bit mode input controls how the upper 128 bits are handled:

- `2'b00`, keep-upper mode: the old destination value acts as the first source. Only lanes 0 to 3 are merged, and bits 255:128 keep their old contents.
- `2'b01`, zero-upper mode: lanes 0 to 3 are merged from the two sources, and bits 255:128 are forced to zero.
- `2'b10`, full-width mode: all eight lanes are merged.
- `2'b11`: reserved. It gives an all-zero result and raises an illegal-mode flag.

The result, the flag and the output valid are registered, so each appears one clock after the input strobe.

Top module: `lane_blend_unit`

## Requirements
- R1: In full-width mode (`mode`=2'b10), result lane i (bits [32i+31:32i], i=0..7) equals `src_b` lane i when `imm[i]`=1, and `src_a` lane i when `imm[i]`=0.
- R2: In zero-upper mode (`mode`=2'b01), result lanes 0..3 follow the R1 rule from `src_a`/`src_b`, and result bits 255:128 are zero.
- R3: In keep-upper mode (`mode`=2'b00), result lane i (i=0..3) equals `src_b` lane i when `imm[i]`=1 and `dst_old` lane i when `imm[i]`=0. Result bits 255:128 equal `dst_old[255:128]`, and `src_a` has no effect on the result.
- R4: In both 128-bit modes (2'b00 and 2'b01), `imm[7:4]` has no effect on the result.
- R5: With `mode`=2'b11, the result is all zero and `bad_mode` is 1. In every other mode, `bad_mode` is 0.
- R6: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1, and `result`/`bad_mode` belong to that input.
- R7: While `rst_n`=0 at a clock edge, `out_valid`, `bad_mode` and `result` are cleared to 0.
- R8: A cycle with `in_valid`=0 leaves `result` and `bad_mode` unchanged and gives `out_valid`=0 in the next cycle.
- R9: Lane bits are copied unchanged, including NaN, infinity and denormal patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| mode | input | 2 | 00 keep-upper, 01 zero-upper, 10 full-width, 11 reserved |
| src_a | input | 256 | First source |
| src_b | input | 256 | Second source |
| dst_old | input | 256 | Current destination value |
| imm | input | 8 | Per-lane select mask |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Merged result |
| bad_mode | output | 1 | Reserved mode was requested |

## Verification
Every result, including the illegal-mode flag, is due exactly one clock after the input strobe. The bench drives inputs on the falling edge. It then checks `out_valid`, `result` and `bad_mode` on the next falling edge, after one rising edge has registered them.

Hold behaviour and reset behaviour are checked the same way. An idle cycle or a reset cycle is applied, and the outputs are sampled one falling edge later.

// File: rtl/lane_blend_pkg.sv
package lane_blend_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP_UP = 2'b00,
        MODE_ZERO_UP = 2'b01,
        MODE_WIDE    = 2'b10,
        MODE_RSVD    = 2'b11
    } blend_mode_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_OLD  = 2'b10,
        SEL_ZERO = 2'b11
    } lane_sel_e;

endpackage

// File: rtl/lane_blend_dec.sv
module lane_blend_dec
    import lane_blend_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic [1:0]                  mode,
    input  logic [NUM_LANES-1:0]        imm,
    output lane_sel_e [NUM_LANES-1:0]   sel,
    output logic                        bad
);
    localparam int HALF_LANES = NUM_LANES / 2;

    always_comb begin
        bad = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            sel[i] = SEL_ZERO;
            unique case (blend_mode_e'(mode))
                MODE_KEEP_UP: begin
                    if (i < HALF_LANES) sel[i] = imm[i] ? SEL_B : SEL_OLD;
                    else                sel[i] = SEL_OLD;
                end
                MODE_ZERO_UP: begin
                    if (i < HALF_LANES) sel[i] = imm[i] ? SEL_B : SEL_A;
                    else                sel[i] = SEL_ZERO;
                end
                MODE_WIDE: sel[i] = imm[i] ? SEL_B : SEL_A;
                default:   sel[i] = SEL_ZERO;
            endcase
        end
        if (blend_mode_e'(mode) == MODE_RSVD) bad = 1'b1;
    end

    // R5
    bad_sel_zero_chk: assert final (!bad || sel == {NUM_LANES{SEL_ZERO}});

endmodule

// File: rtl/lane_blend_mux.sv
module lane_blend_mux
    import lane_blend_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int NUM_LANES = 8
) (
    input  lane_sel_e [NUM_LANES-1:0]       sel,
    input  logic [NUM_LANES*LANE_W-1:0]     a,
    input  logic [NUM_LANES*LANE_W-1:0]     b,
    input  logic [NUM_LANES*LANE_W-1:0]     old,
    output logic [NUM_LANES*LANE_W-1:0]     y
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_comb begin
            unique case (sel[g])
                SEL_A:   y[g*LANE_W +: LANE_W] = a[g*LANE_W +: LANE_W];
                SEL_B:   y[g*LANE_W +: LANE_W] = b[g*LANE_W +: LANE_W];
                SEL_OLD: y[g*LANE_W +: LANE_W] = old[g*LANE_W +: LANE_W];
                default: y[g*LANE_W +: LANE_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/lane_blend_unit.sv
module lane_blend_unit
    import lane_blend_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int NUM_LANES = 8,
    localparam int DATA_W   = LANE_W * NUM_LANES,
    localparam int HALF_W   = DATA_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [DATA_W-1:0]    dst_old,
    input  logic [NUM_LANES-1:0] imm,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic                 bad_mode
);
    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [DATA_W-1:0] res;
    } stage_t;

    lane_sel_e [NUM_LANES-1:0] sel;
    logic                      bad_comb;
    logic [DATA_W-1:0]         blend;
    stage_t                    st_d, st_q;

    lane_blend_dec #(.NUM_LANES(NUM_LANES)) u_dec (
        .mode (mode),
        .imm  (imm),
        .sel  (sel),
        .bad  (bad_comb)
    );

    lane_blend_mux #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_mux (
        .sel  (sel),
        .a    (src_a),
        .b    (src_b),
        .old  (dst_old),
        .y    (blend)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.bad = bad_comb;
            st_d.res = blend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign bad_mode  = st_q.bad;
    assign result    = st_q.res;

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11) |=> (bad_mode && result == '0));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01) |=> (result[DATA_W-1:HALF_W] == '0));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00) |=>
        (result[DATA_W-1:HALF_W] == $past(dst_old[DATA_W-1:HALF_W])));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(bad_mode)));

endmodule

// File: tb/lane_blend_unit_tb.sv
module lane_blend_unit_tb;
    localparam int W = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    mode;
    logic [W-1:0]  src_a, src_b, dst_old;
    logic [7:0]    imm;
    logic          out_valid;
    logic [W-1:0]  result;
    logic          bad_mode;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    always #5 clk = ~clk;

    lane_blend_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .imm(imm),
        .out_valid(out_valid), .result(result), .bad_mode(bad_mode)
    );

    function automatic logic [W-1:0] ref_blend(input logic [1:0] m,
        input logic [W-1:0] a, input logic [W-1:0] b,
        input logic [W-1:0] o, input logic [7:0] k);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            case (m)
                2'b00: r[i*32 +: 32] = (i < 4) ? (k[i] ? b[i*32 +: 32] : o[i*32 +: 32])
                                               : o[i*32 +: 32];
                2'b01: r[i*32 +: 32] = (i < 4) ? (k[i] ? b[i*32 +: 32] : a[i*32 +: 32])
                                               : 32'h0;
                2'b10: r[i*32 +: 32] = k[i] ? b[i*32 +: 32] : a[i*32 +: 32];
                default: r[i*32 +: 32] = 32'h0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd256();
        logic [W-1:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string req, input logic ov, input logic [W-1:0] res,
                         input logic bm);
        n_vec++;
        if (out_valid !== ov || result !== res || bad_mode !== bm) begin
            n_bad++;
            $display("FAIL %s: got vld=%b bad=%b res=%h, exp vld=%b bad=%b res=%h",
                     req, out_valid, bad_mode, result, ov, bm, res);
        end
    endtask

    task automatic apply(input string req, input logic [1:0] m, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] o, input logic [7:0] k);
        in_valid = 1'b1; mode = m; src_a = a; src_b = b; dst_old = o; imm = k;
        @(negedge clk);
        check(req, 1'b1, ref_blend(m, a, b, o, k), m == 2'b11);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] a, b, o, held;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; in_valid = 1'b1; mode = 2'b10; imm = 8'hFF;
        src_a = '1; src_b = '1; dst_old = '1;
        @(negedge clk); @(negedge clk);
        // R7: reset clears everything even with a strobe present
        check("R7", 1'b0, '0, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R3 R5 R6: every mask value in every mode
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 256; k++)
                apply(m == 0 ? "R3" : m == 1 ? "R2" : m == 2 ? "R1" : "R5",
                      2'(m), rnd256(), rnd256(), rnd256(), 8'(k));

        // R4: upper mask bits toggled must not change 128-bit mode results
        for (int m = 0; m < 2; m++)
            for (int t = 0; t < 16; t++) begin
                a = rnd256(); b = rnd256(); o = rnd256();
                apply("R4", 2'(m), a, b, o, {4'h0, 4'(t)});
                in_valid = 1'b1; imm = {4'hF, 4'(t)} ^ {4'($urandom), 4'h0};
                @(negedge clk);
                check("R4", 1'b1, ref_blend(2'(m), a, b, o, {4'h0, 4'(t)}), 1'b0);
            end

        // R3: src_a has no effect in keep-upper mode
        o = rnd256(); b = rnd256();
        apply("R3", 2'b00, '0, b, o, 8'h5A);
        apply("R3", 2'b00, '1, b, o, 8'h5A);

        // R9: NaN / inf / denormal patterns copied bit for bit
        a = {8{32'h7FC00001}}; b = {4{32'h00000001, 32'hFF800000}};
        apply("R9", 2'b10, a, b, '0, 8'hA5);
        apply("R9", 2'b01, {8{32'h7F800001}}, {8{32'h807FFFFF}}, '1, 8'h0C);

        // R8: idle cycles hold result and drop valid
        apply("R8", 2'b10, rnd256(), rnd256(), rnd256(), 8'h3C);
        held = ref_blend(2'b10, src_a, src_b, dst_old, 8'h3C);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b0; mode = 2'($urandom); src_a = rnd256(); src_b = rnd256();
            imm = 8'($urandom);
            @(negedge clk);
            check("R8", 1'b0, held, 1'b0);
        end

        // R5 then back to a legal mode clears the flag
        apply("R5", 2'b11, rnd256(), rnd256(), rnd256(), 8'hFF);
        apply("R5", 2'b01, rnd256(), rnd256(), rnd256(), 8'hFF);

        // R6: back-to-back random traffic
        for (int i = 0; i < 400; i++)
            apply("R6", 2'($urandom), rnd256(), rnd256(), rnd256(), 8'($urandom));

        // R7: reset mid-stream
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R7", 1'b0, '0, 1'b0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule